// File: doc/BRIEF.md
# Fractional-Scaled 64-bit Timebase Counter

This block is the counting core of a system timebase. It holds a 64-bit unsigned count that moves forward on each counter tick. With scaling off, a tick adds one. With scaling on, a tick adds an unsigned fixed-point increment. The increment has an 8-bit integer part and a 24-bit fraction. A hidden fraction accumulator collects the fractional part, and its carry-out adds one more unit to the integer count.

Two increments are preloaded, one for each of two clock sources. A clock-source select input picks which one applies. Software therefore does not need to rewrite the increment when the counter clock switches.

Counting needs the run enable to be set. A debug request freezes the count, and raises a halted flag, when halt-on-debug is enabled. Either 32-bit half of the count can be loaded on its own. Any load clears the hidden fraction.

Top module: `tbs_scaled_counter`

## Requirements
- R1: After reset, `count_o` is 0, the hidden fraction is 0 and `halted_o` is 0.
- R2: Without a load, the count changes only in cycles where `tick_i`, `run_en_i` and not-halted are all true. In every other cycle it holds its value.
- R3: When `scale_en_i` is 0, each counted tick adds exactly 1 and leaves the hidden fraction unchanged.
- R4: When `scale_en_i` is 1, each counted tick adds the selected 32-bit scale value. Bits 31:24 are the integer part, added to the count. Bits 23:0 are the fraction, added to a 24-bit accumulator. A carry out of the accumulator adds 1 more to the count in the same cycle.
- R5: `clk_src_i` = 0 selects `scale_main_i`, and `clk_src_i` = 1 selects `scale_alt_i`. The selection is made in the same cycle as the tick.
- R6: `halted_o` is 1 in any cycle where both `halt_dbg_en_i` and `dbg_req_i` are 1, and the count is then frozen. When `halt_dbg_en_i` is 0, `dbg_req_i` has no effect, so the flag stays 0 and counting continues.
- R7: `load_lo_i` writes `load_data_i` into count bits 31:0 and leaves bits 63:32 unchanged. A load of either half clears the hidden fraction and overrides any tick in that cycle.
- R8: `load_hi_i` writes `load_data_i` into count bits 63:32 and leaves bits 31:0 unchanged.
- R9: When both load inputs are asserted together, both halves take `load_data_i`.
- R10: The count wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Counter tick qualifier |
| run_en_i | input | 1 | Counting enable |
| halt_dbg_en_i | input | 1 | Allow debug requests to freeze the count |
| dbg_req_i | input | 1 | Debug halt request |
| scale_en_i | input | 1 | Use the fixed-point increment instead of +1 |
| clk_src_i | input | 1 | Active clock source: 0 main, 1 alternate |
| scale_main_i | input | 32 | 8.24 increment for the main source |
| scale_alt_i | input | 32 | 8.24 increment for the alternate source |
| load_lo_i | input | 1 | Load count bits 31:0 |
| load_hi_i | input | 1 | Load count bits 63:32 |
| load_data_i | input | 32 | Data for a half load |
| count_o | output | 64 | Current count |
| halted_o | output | 1 | Frozen by debug request |

## Verification
The bound checker watches every cycle for the following:
- the count holds whenever it is disabled or halted;
- an unscaled tick adds exactly one;
- a scaled tick adds the integer part plus at most one carry;
- a half load lands in the right half.

Some behaviour only the bench scenarios can show, because it depends on the hidden fraction across many cycles:
- the exact timing of fraction carries;
- the fraction clear on a load;
- the wrap at 2^64;
- the simultaneous two-half load.

The bench compares these against its own model and against hand-computed values.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
   typedef enum logic {
      SRC_MAIN = 1'b0,
      SRC_ALT  = 1'b1
   } clk_src_e;
endpackage

// File: rtl/tbs_scale_mux.sv
module tbs_scale_mux #(
   parameter int SCALE_W = 32
) (
   input  tbs_pkg::clk_src_e   sel_i,
   input  logic [SCALE_W-1:0]  main_i,
   input  logic [SCALE_W-1:0]  alt_i,
   output logic [SCALE_W-1:0]  scale_o
);
   always_comb begin
      unique case (sel_i)
         tbs_pkg::SRC_ALT: scale_o = alt_i;
         default:          scale_o = main_i;
      endcase
   end
endmodule

// File: rtl/tbs_step_gen.sv
module tbs_step_gen #(
   parameter int CNT_W      = 64,
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 24,
   parameter int SCALE_IMPL = 1
) (
   input  logic                      scale_en_i,
   input  logic [INT_W+FRAC_W-1:0]   scale_i,
   input  logic [FRAC_W-1:0]         frac_i,
   output logic [CNT_W-1:0]          step_o,
   output logic [FRAC_W-1:0]         frac_o
);
   localparam int SCALE_W = INT_W + FRAC_W;

   generate
      if (SCALE_IMPL != 0) begin : g_scaled
         logic [FRAC_W:0] fsum;
         always_comb begin
            fsum = {1'b0, frac_i} + {1'b0, scale_i[FRAC_W-1:0]};
            if (scale_en_i) begin
               step_o = CNT_W'(scale_i[SCALE_W-1:FRAC_W]) + CNT_W'(fsum[FRAC_W]);
               frac_o = fsum[FRAC_W-1:0];
            end else begin
               step_o = CNT_W'(1);
               frac_o = frac_i;
            end
         end
      end else begin : g_plain
         logic unused_scale;
         assign unused_scale = ^{scale_en_i, scale_i};
         assign step_o = CNT_W'(1);
         assign frac_o = frac_i;
      end
   endgenerate
endmodule

// File: rtl/tbs_count_reg.sv
module tbs_count_reg #(
   parameter int CNT_W  = 64,
   parameter int FRAC_W = 24
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv_i,
   input  logic [CNT_W-1:0]     step_i,
   input  logic [FRAC_W-1:0]    frac_nxt_i,
   input  logic                 load_lo_i,
   input  logic                 load_hi_i,
   input  logic [CNT_W/2-1:0]   load_data_i,
   output logic [CNT_W-1:0]     count_o,
   output logic [FRAC_W-1:0]    frac_o
);
   localparam int HALF_W = CNT_W / 2;

   logic [CNT_W-1:0]  count_q;
   logic [FRAC_W-1:0] frac_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         frac_q  <= '0;
      end else if (load_lo_i || load_hi_i) begin
         if (load_lo_i) count_q[HALF_W-1:0]     <= load_data_i;
         if (load_hi_i) count_q[CNT_W-1:HALF_W] <= load_data_i;
         frac_q <= '0;
      end else if (adv_i) begin
         count_q <= count_q + step_i;
         frac_q  <= frac_nxt_i;
      end
   end

   assign count_o = count_q;
   assign frac_o  = frac_q;
endmodule

// File: rtl/tbs_scaled_counter.sv
module tbs_scaled_counter #(
   parameter int CNT_W      = 64,
   parameter int INT_W      = 8,
   parameter int FRAC_W     = 24,
   parameter int SCALE_IMPL = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick_i,
   input  logic                     run_en_i,
   input  logic                     halt_dbg_en_i,
   input  logic                     dbg_req_i,
   input  logic                     scale_en_i,
   input  logic                     clk_src_i,
   input  logic [INT_W+FRAC_W-1:0]  scale_main_i,
   input  logic [INT_W+FRAC_W-1:0]  scale_alt_i,
   input  logic                     load_lo_i,
   input  logic                     load_hi_i,
   input  logic [CNT_W/2-1:0]       load_data_i,
   output logic [CNT_W-1:0]         count_o,
   output logic                     halted_o
);
   localparam int SCALE_W = INT_W + FRAC_W;

   generate
      if ((CNT_W % 2) != 0) begin : g_bad_cnt
         $error("CNT_W must be even so it splits into two load halves");
      end
      if (INT_W < 1 || FRAC_W < 1) begin : g_bad_fmt
         $error("INT_W and FRAC_W must both be at least one bit");
      end
      if (SCALE_W > CNT_W) begin : g_bad_scale
         $error("scale word may not be wider than the count");
      end
   endgenerate

   logic [SCALE_W-1:0] scale_sel;
   logic [CNT_W-1:0]   step;
   logic [FRAC_W-1:0]  frac_q;
   logic [FRAC_W-1:0]  frac_nxt;
   logic               halt_now;
   logic               adv;

   assign halt_now = halt_dbg_en_i & dbg_req_i;
   assign adv      = tick_i & run_en_i & ~halt_now;
   assign halted_o = halt_now;

   tbs_scale_mux #(.SCALE_W(SCALE_W)) u_mux (
      .sel_i   (tbs_pkg::clk_src_e'(clk_src_i)),
      .main_i  (scale_main_i),
      .alt_i   (scale_alt_i),
      .scale_o (scale_sel)
   );

   tbs_step_gen #(
      .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .SCALE_IMPL(SCALE_IMPL)
   ) u_step (
      .scale_en_i (scale_en_i),
      .scale_i    (scale_sel),
      .frac_i     (frac_q),
      .step_o     (step),
      .frac_o     (frac_nxt)
   );

   tbs_count_reg #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .adv_i       (adv),
      .step_i      (step),
      .frac_nxt_i  (frac_nxt),
      .load_lo_i   (load_lo_i),
      .load_hi_i   (load_hi_i),
      .load_data_i (load_data_i),
      .count_o     (count_o),
      .frac_o      (frac_q)
   );
endmodule

// File: rtl/tbs_scaled_counter_chk.sv
module tbs_scaled_counter_chk #(
   parameter int CNT_W  = 64,
   parameter int INT_W  = 8,
   parameter int FRAC_W = 24
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tick_i,
   input logic                     run_en_i,
   input logic                     halt_dbg_en_i,
   input logic                     dbg_req_i,
   input logic                     scale_en_i,
   input logic                     clk_src_i,
   input logic [INT_W+FRAC_W-1:0]  scale_main_i,
   input logic [INT_W+FRAC_W-1:0]  scale_alt_i,
   input logic                     load_lo_i,
   input logic                     load_hi_i,
   input logic [CNT_W/2-1:0]       load_data_i,
   input logic [CNT_W-1:0]         count_o,
   input logic                     halted_o
);
   localparam int SW = INT_W + FRAC_W;
   localparam int HW = CNT_W / 2;

   logic             no_load;
   logic [INT_W-1:0] int_part;
   assign no_load  = ~load_lo_i & ~load_hi_i;
   assign int_part = clk_src_i ? scale_alt_i[SW-1:FRAC_W] : scale_main_i[SW-1:FRAC_W];

   // R2: no enable or no tick means the count holds
   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      no_load && (!run_en_i || !tick_i) |=> $stable(count_o));

   // R6: debug halt freezes the count
   assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
      no_load && halted_o |=> $stable(count_o));

   // R3: unscaled tick adds one
   assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      no_load && tick_i && run_en_i && !halted_o && !scale_en_i
      |=> count_o == $past(count_o) + CNT_W'(1));

   // R4: scaled tick adds integer part plus at most one carry
   assert_scaled_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      no_load && tick_i && run_en_i && !halted_o && scale_en_i
      |=> (count_o - $past(count_o) - CNT_W'($past(int_part))) <= CNT_W'(1));

   // R7: low-half load
   assert_load_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_lo_i |=> count_o[HW-1:0] == $past(load_data_i));

   // R8: high-half load leaves low half alone
   assert_load_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_hi_i && !load_lo_i |=> count_o[CNT_W-1:HW] == $past(load_data_i)
                                && count_o[HW-1:0] == $past(count_o[HW-1:0]));
endmodule

bind tbs_scaled_counter tbs_scaled_counter_chk #(
   .CNT_W(CNT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)
) u_chk (.*);

// File: tb/tbs_scaled_counter_bench.sv
module tbs_scaled_counter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 0, run_en_i = 0, halt_dbg_en_i = 0, dbg_req_i = 0;
   logic        scale_en_i = 0, clk_src_i = 0, load_lo_i = 0, load_hi_i = 0;
   logic [31:0] scale_main_i = '0, scale_alt_i = '0, load_data_i = '0;
   logic [63:0] count_o;
   logic        halted_o;

   int unsigned n_chk = 0, n_fail = 0;
   logic [63:0] ref_cnt = '0;
   logic [23:0] ref_frac = '0;
   bit          done = 0;

   always #10 clk = ~clk;

   tbs_scaled_counter u_tbs_scaled_counter (.*);

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] scale_add(input logic [31:0] s);
      logic [24:0] fs;
      fs = {1'b0, ref_frac} + {1'b0, s[23:0]};
      ref_frac = fs[23:0];
      return 64'(s[31:24]) + 64'(fs[24]);
   endfunction

   // one cycle: drive at negedge, check halt flag, update model, check count after edge
   task automatic cyc(input string req, input logic t, e, he, dr, se, cs, ll, lh,
                      input logic [31:0] d);
      tick_i = t; run_en_i = e; halt_dbg_en_i = he; dbg_req_i = dr;
      scale_en_i = se; clk_src_i = cs; load_lo_i = ll; load_hi_i = lh; load_data_i = d;
      #1;
      check({req, " R6 halted"}, 64'(halted_o), 64'(he & dr));
      if (ll || lh) begin
         if (ll) ref_cnt[31:0] = d;
         if (lh) ref_cnt[63:32] = d;
         ref_frac = '0;
      end else if (t && e && !(he && dr)) begin
         if (se) ref_cnt = ref_cnt + scale_add(cs ? scale_alt_i : scale_main_i);
         else    ref_cnt = ref_cnt + 64'd1;
      end
      @(posedge clk);
      @(negedge clk);
      check({req, " count"}, count_o, ref_cnt);
   endtask

   task automatic tk(input string req, input logic se, cs);
      cyc(req, 1, 1, 0, 0, se, cs, 0, 0, '0);
   endtask

   task automatic ld(input string req, input logic ll, lh, input logic [31:0] d);
      cyc(req, 1, 1, 0, 0, 0, 0, ll, lh, d);
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset count", count_o, 64'd0);
      check("R1 reset halted", 64'(halted_o), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 3; i++) tk("R3 unscaled", 0, 0);
      check("R3 three ticks", count_o, 64'd3);

      cyc("R2 run off", 1, 0, 0, 0, 0, 0, 0, 0, '0);
      cyc("R2 no tick", 0, 1, 0, 0, 0, 0, 0, 0, '0);
      check("R2 hold", count_o, 64'd3);

      scale_main_i = 32'h0180_0000;   // 1.5
      scale_alt_i  = 32'h0040_0000;   // 0.25
      ld("R7 zero", 1, 1, 32'd0);
      for (int i = 0; i < 4; i++) tk("R4 main 1.5", 1, 0);
      check("R4 four ticks of 1.5", count_o, 64'd6);

      ld("R5 zero", 1, 1, 32'd0);
      for (int i = 0; i < 3; i++) tk("R5 alt 0.25", 1, 1);
      check("R5 three quarter ticks", count_o, 64'd0);
      tk("R5 alt 0.25", 1, 1);
      check("R5 carry on fourth", count_o, 64'd1);

      scale_main_i = 32'h0080_0000;   // 0.5
      ld("R7 zero", 1, 1, 32'd0);
      tk("R4 half", 1, 0);
      cyc("R7 load with tick", 1, 1, 0, 0, 1, 0, 1, 0, 32'h10);
      check("R7 load beats tick", count_o, 64'h10);
      tk("R7 half after clear", 1, 0);
      check("R7 fraction cleared", count_o, 64'h10);

      ld("R8 hi load", 0, 1, 32'hA5A5_0001);
      check("R8 high half", count_o, 64'hA5A5_0001_0000_0010);

      ld("R9 both", 1, 1, 32'h1234_5678);
      check("R9 both halves", count_o, 64'h1234_5678_1234_5678);

      cyc("R6 halt", 1, 1, 1, 1, 0, 0, 0, 0, '0);
      check("R6 frozen", count_o, 64'h1234_5678_1234_5678);
      cyc("R6 req ignored", 1, 1, 0, 1, 0, 0, 0, 0, '0);
      check("R6 counts when halt disabled", count_o, 64'h1234_5678_1234_5679);

      ld("R10 lo", 1, 0, 32'hFFFF_FFFE);
      ld("R10 hi", 0, 1, 32'hFFFF_FFFF);
      tk("R10 step", 0, 0);
      tk("R10 step", 0, 0);
      check("R10 wrap to zero", count_o, 64'd0);

      for (int i = 0; i < 3000; i++) begin
         if (($urandom % 64) == 0) scale_main_i = $urandom;
         if (($urandom % 64) == 0) scale_alt_i = $urandom;
         cyc("R4 random", ($urandom % 4) != 0, ($urandom % 8) != 0, $urandom % 2,
             ($urandom % 4) == 0, ($urandom % 3) != 0, $urandom % 2,
             ($urandom % 40) == 0, ($urandom % 40) == 0, $urandom);
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule